// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block models the target side of a two-wire serial EEPROM. It runs on a fast system clock and oversamples the bus clock and data lines. It drives the data line open-drain through an output-enable pin: while `sda_oe_o` is high the pad pulls the line low, and while it is low the line is released. A bus master addresses the block with an 8-bit device word. Through it the master writes one byte or a run of bytes into an internal byte array, or reads bytes back from the current pointer or from an address it has just set.

The array size is a parameter of 256, 512, 1024 or 2048 bytes. The size decides how the three select bits of the device word are used. Some are compared with the hardwired pin inputs `pin_a_i`, and the others become the upper bits of the word address. Received bytes collect in a page buffer. A STOP turns the buffered bytes into a timed write cycle of `WRITE_CLKS` system clocks, and the array is updated when that cycle ends. The write-protect input blocks every commit.

The block has no streaming interface. Both bus lines follow two-wire bus timing and give no back-pressure beyond the acknowledge bit. The master sees a busy array only as a missing acknowledge on its device word.

Top module: `twi_eeprom_target`

## Requirements
- R1: After reset the data line is released (`sda_oe_o` low), and the block ignores bus activity until a START.
- R2: SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. A START received at any point, including in the middle of a transfer, restarts device-word reception. The block changes `sda_oe_o` only while SCL is low.
- R3: The device word is sent MSB first and its four upper bits must be binary 1010. Its select bits 3..1 are compared with `pin_a_i[2:0]`: all three at 256 bytes, bits 3..2 at 512 bytes, bit 3 at 1024 bytes and none at 2048 bytes. The block acknowledges a match by driving SDA low through the ninth SCL clock. When the word does not match, the block gives no acknowledge and ignores the bus until the next START.
- R4: Select bits that are not compared with the pins become the upper bits of the word address: bit 1 at 512 bytes, bits 2..1 at 1024 bytes and bits 3..1 at 2048 bytes. The 8-bit word address byte supplies the lower bits.
- R5: A write is a device word with bit 0 = 0, then a word address byte, then data bytes, and each of these is acknowledged. A STOP after at least one data byte starts a write cycle of `WRITE_CLKS` clocks, and the array takes the new bytes when the cycle ends.
- R6: While a write cycle is running, the block does not acknowledge its device word.
- R7: During a write, the offset within the page wraps and the page stays fixed. A page is 8 bytes for the 256-byte array and 16 bytes for the larger arrays. Only the bytes actually received are committed, and the other bytes of the page keep their contents.
- R8: While `wp_i` is high at the STOP, every byte is still acknowledged, but nothing is committed and no write cycle starts, so the next device word is acknowledged at once.
- R9: A random read is a write-type device word followed by a word address, then a repeated START and a device word with bit 0 = 1. The block then returns the byte at that address, MSB first, with each bit changing after SCL falls.
- R10: During a read, the pointer advances after each byte and wraps across the whole array, from the last address to 0. A master acknowledge (SDA low on the ninth clock) requests the next byte. A master no-acknowledge ends the read, and the block releases SDA.
- R11: A read started without setting an address returns the byte at the pointer left by the previous access. The page bits of a read device word do not change that pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| sda_oe_o | output | 1 | High pulls the data line low; low releases it |
| pin_a_i | input | 3 | Hardwired select pins {A2,A1,A0} |
| wp_i | input | 1 | Write protect; high blocks all commits |

## Verification
The bench puts two instances on one shared wired-AND bus. One is built with `MEM_BYTES`=256 and pins 000, so all three select bits are compared and the page is 8 bytes. The other is built with `MEM_BYTES`=1024 and pins 111, so only bit 3 is compared and pins A1/A0 have no effect. The 1024-byte instance brings the page bits taken from the device word and the 16-byte page wrap within reach. `WRITE_CLKS`=400 is short enough that the bench can place a device word inside a running write cycle and still wait out several cycles.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_ADR,
    ST_ADR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RACK
  } twi_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  // Page length follows the array size.
  function automatic int page_bytes(input int mem_bytes);
    return (mem_bytes <= 256) ? 8 : 16;
  endfunction

endpackage

// File: rtl/twi_line_mon.sv
module twi_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [SYNC_STAGES-1:0] scl_sy, sda_sy;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC_STAGES-2:0], scl_i};
      sda_sy <= {sda_sy[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_sy[SYNC_STAGES-1];
      sda_d  <= sda_sy[SYNC_STAGES-1];
    end
  end

  assign scl_lvl  = scl_sy[SYNC_STAGES-1];
  assign sda_lvl  = sda_sy[SYNC_STAGES-1];
  assign scl_rise = scl_lvl & ~scl_d;
  assign scl_fall = ~scl_lvl & scl_d;
  assign start_ev = scl_d & scl_lvl & sda_d & ~sda_lvl;
  assign stop_ev  = scl_d & scl_lvl & ~sda_d & sda_lvl;

endmodule

// File: rtl/twi_proto_fsm.sv
module twi_proto_fsm
  import twi_eeprom_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  localparam int AW   = $clog2(MEM_BYTES),
  localparam int PAGE = page_bytes(MEM_BYTES),
  localparam int OW   = $clog2(PAGE),
  localparam int PB   = AW - 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_lvl,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic [2:0]    pin_a,
  input  logic          busy_i,
  input  logic [7:0]    rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          push_o,
  output logic [AW-1:0] push_addr_o,
  output logic [7:0]    push_data_o,
  output logic          commit_o,
  output logic          abort_o,
  output logic          sda_oe_o
);

  twi_state_e    st;
  logic [3:0]    cnt;
  logic [7:0]    shreg;
  logic [AW-1:0] ptr;
  logic [2:0]    dev_pg;
  logic          dev_rd;
  logic          mack;
  logic          dev_hit;
  logic [AW-1:0] ptr_pg_inc;

  // Select bits at or above PB are compared with the pins.
  always_comb begin
    dev_hit = (shreg[7:4] == DEV_TYPE) && !busy_i;
    for (int i = 0; i < 3; i++) begin
      if (i >= PB && shreg[i+1] != pin_a[i]) dev_hit = 1'b0;
    end
  end

  assign ptr_pg_inc = {ptr[AW-1:OW], ptr[OW-1:0] + 1'b1};
  assign rd_addr_o  = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      cnt         <= '0;
      shreg       <= '0;
      ptr         <= '0;
      dev_pg      <= '0;
      dev_rd      <= 1'b0;
      mack        <= 1'b0;
      push_o      <= 1'b0;
      push_addr_o <= '0;
      push_data_o <= '0;
      commit_o    <= 1'b0;
      abort_o     <= 1'b0;
      sda_oe_o    <= 1'b0;
    end else begin
      push_o   <= 1'b0;
      commit_o <= 1'b0;
      abort_o  <= 1'b0;
      if (start_ev) begin
        st       <= ST_DEV;
        cnt      <= '0;
        sda_oe_o <= 1'b0;
        abort_o  <= 1'b1;
      end else if (stop_ev) begin
        st       <= ST_IDLE;
        sda_oe_o <= 1'b0;
        commit_o <= 1'b1;
      end else begin
        unique case (st)
          ST_DEV, ST_ADR, ST_WDAT: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_lvl};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (st == ST_DEV) begin
                if (dev_hit) begin
                  dev_rd   <= shreg[0];
                  dev_pg   <= shreg[3:1];
                  sda_oe_o <= 1'b1;
                  st       <= ST_DEV_ACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else if (st == ST_ADR) begin
                ptr      <= AW'({dev_pg, shreg});
                sda_oe_o <= 1'b1;
                st       <= ST_ADR_ACK;
              end else begin
                push_o      <= 1'b1;
                push_addr_o <= ptr;
                push_data_o <= shreg;
                ptr         <= ptr_pg_inc;
                sda_oe_o    <= 1'b1;
                st          <= ST_WDAT_ACK;
              end
            end
          end
          ST_DEV_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (dev_rd) begin
                shreg    <= rd_data_i;
                sda_oe_o <= ~rd_data_i[7];
                ptr      <= ptr + 1'b1;
                st       <= ST_RDAT;
              end else begin
                sda_oe_o <= 1'b0;
                st       <= ST_ADR;
              end
            end
          end
          ST_ADR_ACK, ST_WDAT_ACK: begin
            if (scl_fall) begin
              sda_oe_o <= 1'b0;
              cnt      <= '0;
              st       <= ST_WDAT;
            end
          end
          ST_RDAT: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe_o <= 1'b0;
                cnt      <= '0;
                st       <= ST_RACK;
              end else begin
                shreg    <= {shreg[6:0], 1'b0};
                sda_oe_o <= ~shreg[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_lvl;
            end else if (scl_fall) begin
              if (mack) begin
                shreg    <= rd_data_i;
                sda_oe_o <= ~rd_data_i[7];
                ptr      <= ptr + 1'b1;
                st       <= ST_RDAT;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (st == ST_DEV && !sda_oe_o));

  // R2
  oe_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_lvl);

  // R6
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DEV && scl_fall && cnt == 4'd8 && busy_i && !start_ev && !stop_ev)
    |=> (!sda_oe_o && st == ST_IDLE));

  // R3
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall && (st == ST_ADR_ACK || st == ST_WDAT_ACK)) |=> !sda_oe_o);

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RDAT && scl_rise) |=> $stable(sda_oe_o));

endmodule

// File: rtl/twi_page_store.sv
module twi_page_store
  import twi_eeprom_pkg::*;
#(
  parameter int MEM_BYTES  = 256,
  parameter int WRITE_CLKS = 500,
  localparam int AW   = $clog2(MEM_BYTES),
  localparam int PAGE = page_bytes(MEM_BYTES),
  localparam int OW   = $clog2(PAGE),
  localparam int TW   = $clog2(WRITE_CLKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wp_i,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [7:0]    push_data_i,
  input  logic          commit_i,
  input  logic          abort_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  output logic          busy_o
);

  logic [7:0]       mem    [MEM_BYTES];
  logic [7:0]       pg_buf [PAGE];
  logic [PAGE-1:0]  pg_vld;
  logic [AW-OW-1:0] pg_base;
  logic [TW-1:0]    tmr;
  logic             fire;

  assign busy_o    = (tmr != '0);
  assign fire      = (tmr == TW'(1));
  assign rd_data_o = mem[rd_addr_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_vld  <= '0;
      pg_base <= '0;
      tmr     <= '0;
    end else if (busy_o) begin
      tmr <= tmr - 1'b1;
      if (fire) pg_vld <= '0;
    end else if (commit_i) begin
      if ((|pg_vld) && !wp_i) tmr <= TW'(WRITE_CLKS);
      else                    pg_vld <= '0;
    end else if (abort_i) begin
      pg_vld <= '0;
    end else if (push_i) begin
      pg_vld[push_addr_i[OW-1:0]] <= 1'b1;
      pg_base                     <= push_addr_i[AW-1:OW];
    end
  end

  always_ff @(posedge clk) begin
    if (push_i && !busy_o) pg_buf[push_addr_i[OW-1:0]] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      for (int i = 0; i < PAGE; i++) begin
        if (pg_vld[i]) mem[{pg_base, OW'(i)}] <= pg_buf[i];
      end
    end
  end

  // R8
  wp_no_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && wp_i && !busy_o) |=> !busy_o);

  // R5
  wr_cycle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !wp_i && !busy_o && (|pg_vld)) |=> busy_o);

  // R5
  wr_cycle_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (pg_vld == '0));

endmodule

// File: rtl/twi_eeprom_target.sv
module twi_eeprom_target
  import twi_eeprom_pkg::*;
#(
  parameter int MEM_BYTES   = 256,
  parameter int WRITE_CLKS  = 500,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(MEM_BYTES)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] pin_a_i,
  input  logic       wp_i
);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  logic          busy, push, commit, abort;
  logic [AW-1:0] rd_addr, push_addr;
  logic [7:0]    rd_data, push_data;

  twi_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  twi_proto_fsm #(.MEM_BYTES(MEM_BYTES)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_lvl     (scl_lvl),
    .sda_lvl     (sda_lvl),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_ev    (start_ev),
    .stop_ev     (stop_ev),
    .pin_a       (pin_a_i),
    .busy_i      (busy),
    .rd_data_i   (rd_data),
    .rd_addr_o   (rd_addr),
    .push_o      (push),
    .push_addr_o (push_addr),
    .push_data_o (push_data),
    .commit_o    (commit),
    .abort_o     (abort),
    .sda_oe_o    (sda_oe_o)
  );

  twi_page_store #(.MEM_BYTES(MEM_BYTES), .WRITE_CLKS(WRITE_CLKS)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .wp_i        (wp_i),
    .push_i      (push),
    .push_addr_i (push_addr),
    .push_data_i (push_data),
    .commit_i    (commit),
    .abort_i     (abort),
    .rd_addr_i   (rd_addr),
    .rd_data_o   (rd_data),
    .busy_o      (busy)
  );

endmodule

// File: tb/sim_twi_eeprom_target.sv
module sim_twi_eeprom_target;

  localparam int H    = 8;
  localparam int WCLK = 400;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl   = 1'b1;
  logic sda_m = 1'b1;
  logic wp    = 1'b0;
  logic oe0, oe1, sda_bus;

  assign sda_bus = sda_m & ~oe0 & ~oe1;

  twi_eeprom_target #(.MEM_BYTES(256), .WRITE_CLKS(WCLK)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(oe0), .pin_a_i(3'b000), .wp_i(wp));

  twi_eeprom_target #(.MEM_BYTES(1024), .WRITE_CLKS(WCLK)) u1 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(oe1), .pin_a_i(3'b111), .wp_i(wp));

  int    n_run  = 0;
  int    n_fail = 0;
  int    exp_v[$];
  string exp_r[$];
  int    obs_v[$];

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_item(input int v, input string r);
    exp_v.push_back(v);
    exp_r.push_back(r);
  endtask

  // Scoreboard monitor: pairs each observation with the oldest expectation.
  initial begin
    forever begin
      @(negedge clk);
      while (obs_v.size() > 0 && exp_v.size() > 0) begin
        int    got, want;
        string rq;
        got  = obs_v.pop_front();
        want = exp_v.pop_front();
        rq   = exp_r.pop_front();
        n_run++;
        if (got != want) begin
          n_fail++;
          $display("FAIL %s: got %0h expected %0h", rq, got, want);
        end
      end
    end
  end

  task automatic bus_start();
    tick(2); sda_m = 1'b1; tick(H); scl = 1'b1; tick(H);
    sda_m = 1'b0; tick(H); scl = 1'b0;
  endtask

  task automatic bus_stop();
    tick(2); sda_m = 1'b0; tick(H); scl = 1'b1; tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  // Sends a byte; records the acknowledge bit (0 = acknowledged).
  task automatic wr8(input logic [7:0] b, input int ack_exp, input string r);
    expect_item(ack_exp, r);
    for (int i = 7; i >= 0; i--) begin
      tick(2); sda_m = b[i]; tick(H-2); scl = 1'b1; tick(H); scl = 1'b0;
    end
    tick(2); sda_m = 1'b1; tick(H-2); scl = 1'b1; tick(H/2);
    obs_v.push_back(int'(sda_bus));
    tick(H/2); scl = 1'b0;
  endtask

  // Receives a byte, then sends ACK (mack=1) or NACK.
  task automatic rd8(input logic [7:0] e, input bit mack, input string r);
    logic [7:0] v;
    v = '0;
    expect_item(int'(e), r);
    for (int i = 0; i < 8; i++) begin
      tick(2); sda_m = 1'b1; tick(H-2); scl = 1'b1; tick(H/2);
      v = {v[6:0], sda_bus};
      tick(H/2); scl = 1'b0;
    end
    tick(2); sda_m = mack ? 1'b0 : 1'b1; tick(H-2); scl = 1'b1; tick(H);
    scl = 1'b0; tick(2); sda_m = 1'b1;
    obs_v.push_back(int'(v));
  endtask

  task automatic rand_addr(input logic [7:0] dev, input logic [7:0] adr, input string r);
    bus_start(); wr8(dev, 0, r); wr8(adr, 0, r);
    bus_start(); wr8(dev | 8'h01, 0, r);
  endtask

  initial begin
    tick(5); rst_n = 1'b1; tick(5);
    // R1: released after reset
    expect_item(0, "R1"); obs_v.push_back(int'(oe0));
    expect_item(0, "R1"); obs_v.push_back(int'(oe1));

    // R5: byte write 0x10 = 5A
    bus_start(); wr8(8'hA0, 0, "R3"); wr8(8'h10, 0, "R5"); wr8(8'h5A, 0, "R5"); bus_stop();
    // R6: device word refused during write cycle
    bus_start(); wr8(8'hA0, 1, "R6"); bus_stop();
    tick(WCLK + 50);

    // R9, R2: random read through repeated START
    rand_addr(8'hA0, 8'h10, "R9"); rd8(8'h5A, 1'b0, "R9"); bus_stop();

    // R7: full page 0x18..0x1F, then partial wrap from 0x1E
    bus_start(); wr8(8'hA0, 0, "R7"); wr8(8'h18, 0, "R7");
    for (int i = 0; i < 8; i++) wr8(8'h80 + 8'(i), 0, "R7");
    bus_stop(); tick(WCLK + 50);
    bus_start(); wr8(8'hA0, 0, "R7"); wr8(8'h1E, 0, "R7");
    wr8(8'h11, 0, "R7"); wr8(8'h22, 0, "R7"); wr8(8'h33, 0, "R7"); wr8(8'h44, 0, "R7");
    bus_stop(); tick(WCLK + 50);
    rand_addr(8'hA0, 8'h18, "R7");
    rd8(8'h33, 1'b1, "R7"); rd8(8'h44, 1'b1, "R7"); rd8(8'h82, 1'b1, "R7");
    rd8(8'h83, 1'b1, "R7"); rd8(8'h84, 1'b1, "R7"); rd8(8'h85, 1'b1, "R10");
    rd8(8'h11, 1'b1, "R7"); rd8(8'h22, 1'b0, "R7"); bus_stop();

    // R10: array wrap from 0xFF to 0x00
    bus_start(); wr8(8'hA0, 0, "R5"); wr8(8'hFF, 0, "R5"); wr8(8'hC3, 0, "R5"); bus_stop();
    tick(WCLK + 50);
    bus_start(); wr8(8'hA0, 0, "R5"); wr8(8'h00, 0, "R5"); wr8(8'h3C, 0, "R5"); bus_stop();
    tick(WCLK + 50);
    rand_addr(8'hA0, 8'hFF, "R10"); rd8(8'hC3, 1'b1, "R10"); rd8(8'h3C, 1'b0, "R10"); bus_stop();
    // R11: current read after a single-byte read at 0xFF
    rand_addr(8'hA0, 8'hFF, "R11"); rd8(8'hC3, 1'b0, "R11"); bus_stop();
    bus_start(); wr8(8'hA1, 0, "R11"); rd8(8'h3C, 1'b0, "R11"); bus_stop();

    // R8: write-protected write is acknowledged but not kept
    wp = 1'b1;
    bus_start(); wr8(8'hA0, 0, "R8"); wr8(8'h10, 0, "R8"); wr8(8'hEE, 0, "R8"); bus_stop();
    wp = 1'b0;
    rand_addr(8'hA0, 8'h10, "R8"); rd8(8'h5A, 1'b0, "R8"); bus_stop();

    // R3: non-matching word, following bytes ignored
    bus_start(); wr8(8'hA2, 1, "R3"); wr8(8'h00, 1, "R3"); bus_stop();

    // R4, R7: 1024-byte instance, page 2 offset 0x3E, 16-byte page wrap
    bus_start(); wr8(8'hAC, 0, "R4"); wr8(8'h3E, 0, "R4");
    wr8(8'h61, 0, "R7"); wr8(8'h62, 0, "R7"); wr8(8'h63, 0, "R7"); bus_stop();
    tick(WCLK + 50);
    bus_start(); wr8(8'hA8, 0, "R4"); wr8(8'h30, 0, "R4"); wr8(8'h99, 0, "R4"); bus_stop();
    tick(WCLK + 50);
    rand_addr(8'hAC, 8'h3E, "R4"); rd8(8'h61, 1'b1, "R4"); rd8(8'h62, 1'b0, "R4"); bus_stop();
    rand_addr(8'hAC, 8'h30, "R7"); rd8(8'h63, 1'b0, "R7"); bus_stop();
    rand_addr(8'hA8, 8'h30, "R4"); rd8(8'h99, 1'b0, "R4"); bus_stop();

    tick(20);
    if (exp_v.size() != 0 || obs_v.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: got %0d unmatched expected %0d", obs_v.size(), exp_v.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_run++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule